// File: doc/BRIEF.md
# Loss-of-Signal Detector with Hysteresis

This block decides whether a receive line carries a usable signal. Each cycle of the recovered receive clock, an upstream slicer reports whether it saw signal energy. The block turns that raw, noisy per-cycle indication into a stable, active-low loss flag. The flag falls only after an unbroken run of absent cycles. It rises only after an unbroken run of present cycles. Both runs use the same programmable length, so short dropouts and short bursts of noise do not make the flag toggle.

While loss is declared, the block forces both receive data rails (positive and negative pulse) to zero. Downstream decoders therefore never see garbage from a dead line. When the signal is good, the rails pass straight through.

The run length comes from a port. A zero value selects a default of 175 cycles, and other values are held to the range 100 to 250. The flag comes out of reset in the loss state.

Top module: `los_detector`

## Requirements
- R1: During reset and on the first sampled cycle after reset, `los_n` is 0 (loss), and any earlier partial run is discarded.
- R2: With `los_n` = 0, `los_n` rises to 1 on the clock edge that samples the W-th consecutive cycle with `sig_present` = 1. It stays 0 after W-1 such cycles.
- R3: With `los_n` = 1, `los_n` falls to 0 on the clock edge that samples the W-th consecutive cycle with `sig_present` = 0. It stays 1 after W-1 such cycles.
- R4: A single sampled cycle whose `sig_present` matches the current state (1 while `los_n` = 1, 0 while `los_n` = 0) restarts the run. A full W further opposing cycles are then needed before the flag changes.
- R5: While `los_n` = 0, `rx_pos_out` and `rx_neg_out` are 0 whatever `rx_pos_in` and `rx_neg_in` carry.
- R6: While `los_n` = 1, `rx_pos_out` equals `rx_pos_in` and `rx_neg_out` equals `rx_neg_in` in the same cycle, with no register delay.
- R7: The effective window W is derived from `win_len` as follows:
  - 0 selects 175.
  - Values 1 to 99 give 100.
  - Values 100 to 250 are used as given.
  - Values 251 to 255 give 250.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_present | input | 1 | Per-cycle signal-present indication from the slicer |
| win_len | input | 8 | Programmed run length (0 selects the default) |
| rx_pos_in | input | 1 | Positive pulse rail from the slicer |
| rx_neg_in | input | 1 | Negative pulse rail from the slicer |
| rx_pos_out | output | 1 | Gated positive pulse rail |
| rx_neg_out | output | 1 | Gated negative pulse rail |
| los_n | output | 1 | Loss flag, 0 = signal lost |

## Verification
The flag is registered. It changes on exactly the edge that samples the W-th opposing cycle. The bench therefore drives inputs 5 ns after a rising edge, reads `los_n` 5 ns after the edge that samples the (W-1)-th opposing cycle (expecting no change), and reads it again after the W-th edge (expecting the toggle). W is computed in the bench from `win_len` using the R7 rule.

The data rails are gated combinationally. Their values are checked in the same cycle that new rail inputs are applied, once in each flag state.

A break cycle is inserted after W-1 opposing cycles. The bench then confirms that a further W-1 cycles still leave the flag unchanged, and that the W-th cycle toggles it.

// File: rtl/los_pkg.sv
// Package: shared types for the loss-of-signal detector.
// Assumes: the flag state is encoded so that its bit value equals the
// active-low output level.
package los_pkg;

    typedef enum logic {
        ST_LOST = 1'b0,
        ST_GOOD = 1'b1
    } los_state_e;

endpackage

// File: rtl/los_win_sel.sv
// Module: los_win_sel
// Derives the effective run length from the programmed value. Zero picks
// the default, and everything else is held inside [WIN_MIN, WIN_MAX].
// Assumes: WIN_MIN <= WIN_DEF <= WIN_MAX < 2**CNT_W.
module los_win_sel #(
    parameter int CNT_W   = 8,
    parameter int WIN_MIN = 100,
    parameter int WIN_MAX = 250,
    parameter int WIN_DEF = 175
) (
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] win_eff
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(WIN_MIN);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(WIN_MAX);
    localparam logic [CNT_W-1:0] DEF_V = CNT_W'(WIN_DEF);

    // Select default, lower bound, upper bound or the programmed value.
    always_comb begin
        if (win_len == '0)
            win_eff = DEF_V;
        else if (win_len < MIN_V)
            win_eff = MIN_V;
        else if (win_len > MAX_V)
            win_eff = MAX_V;
        else
            win_eff = win_len;
    end

    // R7: effective window always inside the allowed range
    always_comb begin
        p_win_in_range_r7: assert (win_eff >= MIN_V && win_eff <= MAX_V);
    end

endmodule

// File: rtl/los_run_cnt.sv
// Module: los_run_cnt
// Counts consecutive cycles of the "opposing" condition. It pulses done on
// the cycle that completes a full run and then starts over. Any cycle
// without the opposing condition clears the count.
// Assumes: win_eff >= 1 and win_eff <= WIN_MAX.
module los_run_cnt #(
    parameter int CNT_W   = 8,
    parameter int WIN_MAX = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             opposing,
    input  logic [CNT_W-1:0] win_eff,
    output logic [CNT_W-1:0] run_cnt,
    output logic             done
);
    localparam logic [CNT_W:0] ONE_EXT = (CNT_W+1)'(1);

    logic [CNT_W:0] cnt_next_ext;

    // Count including the present cycle, widened to avoid wrap.
    always_comb begin
        cnt_next_ext = {1'b0, run_cnt} + ONE_EXT;
        done         = opposing && (cnt_next_ext >= {1'b0, win_eff});
    end

    // Advance, restart on a break, or wrap to zero on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else if (!opposing || done)
            run_cnt <= '0;
        else
            run_cnt <= cnt_next_ext[CNT_W-1:0];
    end

    // R4: a break cycle leaves the count at zero
    p_break_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !opposing |=> run_cnt == '0);

    // R2/R3: the count never runs past the largest window
    p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt < CNT_W'(WIN_MAX));

endmodule

// File: rtl/los_flag.sv
// Module: los_flag
// Holds the loss/good state and toggles it when the run counter reports
// a completed window. Resets to the loss state.
// Assumes: done is only raised while the input opposes the current state.
module los_flag
    import los_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       done,
    output los_state_e state
);
    // Toggle the state on completion of a window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_LOST;
        else if (done)
            state <= (state == ST_LOST) ? ST_GOOD : ST_LOST;
    end

    // R2/R3: the state changes only on a completed window
    p_change_needs_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state != $past(state) |-> $past(done));

endmodule

// File: rtl/los_detector.sv
// Module: los_detector (top)
// Loss-of-signal detector with symmetric hysteresis windows and receive
// data gating. The flag is registered. The data rails are gated
// combinationally by the registered flag.
// Assumes: all inputs are synchronous to clk.
module los_detector
    import los_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int WIN_MIN = 100,
    parameter int WIN_MAX = 250,
    parameter int WIN_DEF = 175,
    parameter int RAILS   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_present,
    input  logic [CNT_W-1:0] win_len,
    input  logic             rx_pos_in,
    input  logic             rx_neg_in,
    output logic             rx_pos_out,
    output logic             rx_neg_out,
    output logic             los_n
);
    logic [CNT_W-1:0] win_eff;
    logic [CNT_W-1:0] run_cnt;
    logic             done;
    logic             opposing;
    los_state_e       state;
    logic [RAILS-1:0] rail_in;
    logic [RAILS-1:0] rail_out;

    los_win_sel #(
        .CNT_W  (CNT_W),
        .WIN_MIN(WIN_MIN),
        .WIN_MAX(WIN_MAX),
        .WIN_DEF(WIN_DEF)
    ) u_win_sel (
        .win_len(win_len),
        .win_eff(win_eff)
    );

    // Opposing means the input disagrees with the current state.
    always_comb begin
        opposing = (state == ST_LOST) ? sig_present : !sig_present;
    end

    los_run_cnt #(
        .CNT_W  (CNT_W),
        .WIN_MAX(WIN_MAX)
    ) u_run_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .opposing(opposing),
        .win_eff (win_eff),
        .run_cnt (run_cnt),
        .done    (done)
    );

    los_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .done (done),
        .state(state)
    );

    // Drive the active-low flag from the state.
    always_comb begin
        los_n = (state == ST_GOOD);
    end

    // Collect the rails into a vector for uniform gating.
    always_comb begin
        rail_in = '0;
        rail_in[0] = rx_pos_in;
        rail_in[1] = rx_neg_in;
    end

    // One gate per rail, each closed while loss is declared.
    for (genvar g = 0; g < RAILS; g++) begin : g_rail
        always_comb begin
            rail_out[g] = rail_in[g] & los_n;
        end
    end

    // Present the gated rails on the ports.
    always_comb begin
        rx_pos_out = rail_out[0];
        rx_neg_out = rail_out[1];
    end

    // R1: the first cycle after reset is in loss
    p_loss_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !los_n);

    // R2: a rise only follows a sampled present cycle
    p_rise_needs_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_n) |-> $past(sig_present));

    // R3: a fall only follows a sampled absent cycle
    p_fall_needs_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_n) |-> !$past(sig_present));

    // R5: rails are quiet while loss is declared
    p_rails_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !los_n |-> (!rx_pos_out && !rx_neg_out));

endmodule

// File: tb/los_detector_tb.sv
// Bench: sweeps programmed window values, computes W arithmetically and
// checks the flag at W-1 and W sampled cycles, with break cycles and
// rail gating checks in both states.
module los_detector_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_present = 1'b0;
    logic [7:0] win_len = 8'd0;
    logic       rx_pos_in = 1'b0;
    logic       rx_neg_in = 1'b0;
    logic       rx_pos_out;
    logic       rx_neg_out;
    logic       los_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    los_detector u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_present(sig_present),
        .win_len    (win_len),
        .rx_pos_in  (rx_pos_in),
        .rx_neg_in  (rx_neg_in),
        .rx_pos_out (rx_pos_out),
        .rx_neg_out (rx_neg_out),
        .los_n      (los_n)
    );

    function automatic int exp_win(input int v);
        if (v == 0) return 175;
        if (v < 100) return 100;
        if (v > 250) return 250;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (win_len=%0d)", req, act, exp, win_len);
        end
    endtask

    // Apply a level for n sampled cycles; ends 5 ns after the last edge.
    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            sig_present = v;
            @(posedge clk);
            #5;
        end
    endtask

    task automatic rails(input logic flag);
        for (int p = 0; p < 4; p++) begin
            rx_pos_in = p[0];
            rx_neg_in = p[1];
            #1;
            if (flag) begin
                chk("R6 pos", rx_pos_out, p[0]);
                chk("R6 neg", rx_neg_out, p[1]);
            end else begin
                chk("R5 pos", rx_pos_out, 0);
                chk("R5 neg", rx_neg_out, 0);
            end
        end
        rx_pos_in = 1'b0;
        rx_neg_in = 1'b0;
    endtask

    task automatic do_reset(input int v);
        rst_n = 1'b0;
        win_len = 8'(v);
        sig_present = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 in reset", los_n, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        int vals[9] = '{0, 1, 99, 100, 101, 175, 249, 250, 255};
        #5;
        foreach (vals[k]) begin
            int w;
            w = exp_win(vals[k]);
            do_reset(vals[k]);
            hold(1'b0, 1);
            chk("R1 after reset", los_n, 0);
            rails(1'b0);
            // R2 with a break after W-1 (R4)
            hold(1'b1, w - 1);
            chk("R2 at W-1", los_n, 0);
            hold(1'b0, 1);
            chk("R4 break in loss", los_n, 0);
            hold(1'b1, w - 1);
            chk("R4 W-1 after break", los_n, 0);
            hold(1'b1, 1);
            chk("R2 at W (R7 window)", los_n, 1);
            rails(1'b1);
            // R3 with a break after W-1 (R4)
            hold(1'b0, w - 1);
            chk("R3 at W-1", los_n, 1);
            hold(1'b1, 1);
            chk("R4 break in good", los_n, 1);
            hold(1'b0, w - 1);
            chk("R4 W-1 after break", los_n, 1);
            hold(1'b0, 1);
            chk("R3 at W (R7 window)", los_n, 0);
            rails(1'b0);
            // partial run discarded by reset (R1)
            hold(1'b1, w - 1);
            do_reset(vals[k]);
            hold(1'b1, 1);
            chk("R1 partial run discarded", los_n, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0 (timeout)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule